// File: doc/BRIEF.md
# Single-Wire ROM Identity Responder

This block is the device side of a single-wire, open-drain identification link. It holds a fixed 64-bit identity word made of an 8-bit family code, a 48-bit serial number and an 8-bit check byte. The word is set at build time through a parameter. The block watches the shared line for a long low reset pulse and answers it with a presence pulse. It then receives an 8-bit command. Two commands are supported. Read-identity shifts out all 64 bits. Search runs the bit-by-bit elimination walk that lets a host find every device on a shared line. Any other command code leaves the device quiet until the next reset.

All timing is counted in microseconds from a one-cycle `us_tick` strobe. The line input must already be synchronised to `clk`. The block never drives the line high. It only asserts `pull_low`, which enables an external open-drain pull-down, so several responders on one line combine as a wired-AND. Two status outputs are provided. `busy` is high while a command or transfer is in progress. `dropped` is high once this device has left a search because it lost a bit.

Top module: `owire_rom_slave`

## Requirements
- R1: After `rst_n` is released, `pull_low`, `busy` and `dropped` are low. The device gives no presence pulse and answers no slot until it has seen a valid reset pulse.
- R2: A line low time of RST_US (480) microseconds or more counts as a reset from any state. It ends any transaction in progress, clears `dropped` and releases the line.
- R3: The presence pulse follows only a valid reset. It starts PRES_WAIT_US (30, within 15 to 60) microseconds after the line rises and stays low for PRES_LOW_US (120, within 60 to 240) microseconds. A low pulse shorter than RST_US produces no presence pulse.
- R4: After the presence pulse, `busy` is high and the device receives 8 command bits, least significant first. Each bit is sampled SAMPLE_US (30) microseconds after the falling edge that opens its slot.
- R5: Command 0x33 sends the 64 identity bits starting with bit 0. Bits 7:0 hold the family code, bits 55:8 the serial number and bits 63:56 the check byte. A 0 is sent by pulling the line low for HOLD_US (30) microseconds from the host's falling edge. `busy` falls after bit 63.
- R6: Command 0xF0 runs 64 triplets starting at identity bit 0. In each triplet the device sends its bit in the first slot and the inverse of that bit in the second slot. In the third slot it reads the bit the host writes.
- R7: When the host's search bit differs from the device's bit, the device sets `dropped`, lowers `busy` and keeps the line released until the next reset. A device that matches all 64 bits ends with `busy` low and `dropped` low.
- R8: Any command other than 0x33 and 0xF0 (for example 0x55, 0xCC or 0xA5) makes the device silent, with `busy` low, until the next reset.
- R9: The device only ever pulls the line low. When two devices transmit in the same slot, the line shows the AND of their bits.
- R10: A new reset clears `dropped`, and a new transaction then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| line_in | input | 1 | Synchronised level of the shared line |
| pull_low | output | 1 | Enables the open-drain pull-down on the line |
| busy | output | 1 | A command or transfer is in progress |
| dropped | output | 1 | The device has left the current search |

## Verification
Two functions can meet in the same cycle. The long-low reset detector can fire while a slot is still in progress, even while the device is pulling the line for a 0 bit. The bench provokes this by issuing a full reset partway through a read transfer. The reset must win: `busy` must drop, a fresh presence pulse must follow, and the next command must start from identity bit 0. In the search, the sample of the third slot decides drop-out at the same edge that would otherwise advance the bit index. Two responders with different identities share one line, and the bench checks that the loser releases at once while the winner keeps going.

// File: rtl/owrs_pkg.sv
// Shared types and command codes for the single-wire ROM responder.
// Assumes: command codes are compared after all 8 bits have arrived.
package owrs_pkg;

    typedef enum logic [2:0] {
        ST_SILENT,   // waiting for a valid reset, line released
        ST_RSTLOW,   // long low seen, waiting for the line to rise
        ST_PRES,     // presence pulse sequence running
        ST_CMD,      // receiving the 8-bit command
        ST_READ,     // shifting the identity word out
        ST_SRCH      // running search triplets
    } owrs_state_t;

    localparam logic [7:0] CMD_READ_ID = 8'h33;
    localparam logic [7:0] CMD_SEARCH  = 8'hF0;

endpackage

// File: rtl/owrs_line_mon.sv
// Line monitor: finds host falling edges, times each slot and each low period.
// Assumes: line_in is already synchronised; us_tick is a one-cycle strobe.
module owrs_line_mon #(
    parameter int RST_US    = 480,
    parameter int SAMPLE_US = 30,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          line_in,
    output logic          fall,
    output logic          samp,
    output logic          long_low,
    output logic [CW-1:0] slot_us
);

    logic          line_q;
    logic [CW-1:0] low_us;

    assign fall     = line_q && !line_in;
    assign samp     = us_tick && !fall && (slot_us == CW'(SAMPLE_US - 1));
    assign long_low = (low_us == CW'(RST_US));

    // Delay the line level by one cycle to find falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_in;
    end

    // Count microseconds since the last falling edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         slot_us <= '1;
        else if (fall)                      slot_us <= '0;
        else if (us_tick && slot_us != '1)  slot_us <= slot_us + 1'b1;
    end

    // Count microseconds of continuous low level, saturating at the reset limit.
    always_ff @(posedge clk) begin
        if (!rst_n || line_in)                          low_us <= '0;
        else if (us_tick && low_us < CW'(RST_US))       low_us <= low_us + 1'b1;
    end

endmodule

// File: rtl/owrs_presence.sv
// Presence pulse generator: waits WAIT_US after start, then pulls low for LOW_US.
// Assumes: start is a single-cycle pulse at the rising edge that ends a reset.
module owrs_presence #(
    parameter int WAIT_US = 30,
    parameter int LOW_US  = 120,
    parameter int CW      = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic start,
    input  logic abort,
    output logic drive,
    output logic done
);

    localparam int TOTAL_US = WAIT_US + LOW_US;

    logic          run;
    logic [CW-1:0] cnt;

    assign drive = run && (cnt >= CW'(WAIT_US));
    assign done  = run && us_tick && !abort && (cnt == CW'(TOTAL_US - 1));

    // Step through the wait and low phases of the presence pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (abort) begin
            run <= 1'b0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run && us_tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(TOTAL_US - 1)) run <= 1'b0;
        end
    end

endmodule

// File: rtl/owrs_ctrl.sv
// Transaction controller: command receive, identity read-out and search triplets.
// Assumes: fall/samp/long_low come from owrs_line_mon and never coincide with each other.
module owrs_ctrl
    import owrs_pkg::*;
#(
    parameter logic [63:0] ROM_CODE = 64'h5E00_A1B2_C3D4_E528,
    parameter int          HOLD_US  = 30,
    parameter int          CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          samp,
    input  logic          long_low,
    input  logic          line_in,
    input  logic          pres_done,
    input  logic [CW-1:0] slot_us,
    output logic          pres_start,
    output logic          tx_drive,
    output logic          busy,
    output logic          dropped
);

    owrs_state_t state;
    logic [5:0]  bit_idx;
    logic [1:0]  phase;
    logic [7:0]  cmd_sr;
    logic [2:0]  cmd_cnt;
    logic        tx_zero;
    logic        rom_bit;
    logic        tx_en;
    logic        tx_val;
    logic [7:0]  cmd_next;

    assign rom_bit    = ROM_CODE[bit_idx];
    assign cmd_next   = {line_in, cmd_sr[7:1]};
    assign pres_start = (state == ST_RSTLOW) && line_in && !long_low;
    assign busy       = (state == ST_CMD) || (state == ST_READ) || (state == ST_SRCH);
    assign tx_drive   = tx_zero && ((state == ST_READ) || (state == ST_SRCH))
                        && (slot_us < CW'(HOLD_US));

    // Choose whether this slot carries a device bit and which value.
    always_comb begin
        tx_en  = 1'b0;
        tx_val = 1'b1;
        if (state == ST_READ) begin
            tx_en  = 1'b1;
            tx_val = rom_bit;
        end else if (state == ST_SRCH && phase != 2'd2) begin
            tx_en  = 1'b1;
            tx_val = (phase == 2'd0) ? rom_bit : !rom_bit;
        end
    end

    // Main sequence: reset abort has priority over every slot event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SILENT;
            bit_idx <= '0;
            phase   <= '0;
            cmd_sr  <= '0;
            cmd_cnt <= '0;
            tx_zero <= 1'b0;
            dropped <= 1'b0;
        end else if (long_low) begin
            state   <= ST_RSTLOW;
            tx_zero <= 1'b0;
            dropped <= 1'b0;
        end else begin
            if (fall) tx_zero <= tx_en && !tx_val;
            case (state)
                ST_RSTLOW: if (line_in) state <= ST_PRES;
                ST_PRES: begin
                    if (pres_done) begin
                        state   <= ST_CMD;
                        cmd_cnt <= '0;
                    end
                end
                ST_CMD: begin
                    if (samp) begin
                        cmd_sr  <= cmd_next;
                        cmd_cnt <= cmd_cnt + 1'b1;
                        bit_idx <= '0;
                        phase   <= '0;
                        if (cmd_cnt == 3'd7) begin
                            if (cmd_next == CMD_READ_ID)     state <= ST_READ;
                            else if (cmd_next == CMD_SEARCH) state <= ST_SRCH;
                            else                             state <= ST_SILENT;
                        end
                    end
                end
                ST_READ: begin
                    if (samp) begin
                        if (bit_idx == 6'd63) state   <= ST_SILENT;
                        else                  bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_SRCH: begin
                    if (samp) begin
                        if (phase != 2'd2) begin
                            phase <= phase + 1'b1;
                        end else if (line_in != rom_bit) begin
                            dropped <= 1'b1;
                            state   <= ST_SILENT;
                        end else begin
                            phase <= '0;
                            if (bit_idx == 6'd63) state   <= ST_SILENT;
                            else                  bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/owire_rom_slave.sv
// Top: single-wire ROM identity responder with read-out and search.
// Assumes: line_in synchronised to clk; pull_low drives an external open-drain pull-down.
module owire_rom_slave #(
    parameter logic [63:0] ROM_CODE     = 64'h5E00_A1B2_C3D4_E528,
    parameter int          RST_US       = 480,
    parameter int          PRES_WAIT_US = 30,
    parameter int          PRES_LOW_US  = 120,
    parameter int          HOLD_US      = 30,
    parameter int          SAMPLE_US    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    output logic pull_low,
    output logic busy,
    output logic dropped
);

    localparam int CW = $clog2(RST_US + PRES_WAIT_US + PRES_LOW_US + 2) + 1;

    logic          fall;
    logic          samp;
    logic          long_low;
    logic [CW-1:0] slot_us;
    logic          pres_start;
    logic          pres_drive;
    logic          pres_done;
    logic          tx_drive;

    owrs_line_mon #(.RST_US(RST_US), .SAMPLE_US(SAMPLE_US), .CW(CW)) u_mon (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
        .fall(fall), .samp(samp), .long_low(long_low), .slot_us(slot_us)
    );

    owrs_presence #(.WAIT_US(PRES_WAIT_US), .LOW_US(PRES_LOW_US), .CW(CW)) u_pres (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(pres_start),
        .abort(long_low), .drive(pres_drive), .done(pres_done)
    );

    owrs_ctrl #(.ROM_CODE(ROM_CODE), .HOLD_US(HOLD_US), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fall(fall), .samp(samp), .long_low(long_low),
        .line_in(line_in), .pres_done(pres_done), .slot_us(slot_us),
        .pres_start(pres_start), .tx_drive(tx_drive), .busy(busy), .dropped(dropped)
    );

    // Open-drain output: either source may pull the line low.
    assign pull_low = pres_drive || tx_drive;

endmodule

// File: rtl/owrs_checker.sv
// Checker for owire_rom_slave, attached by bind; watches ports only.
// Assumes: us_tick is the same strobe the block uses.
module owrs_checker #(
    parameter int RST_US = 480
) (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic line_in,
    input logic pull_low,
    input logic busy,
    input logic dropped
);

    logic [15:0] low_cnt;
    logic        armed;

    // Independent count of the current low period.
    always_ff @(posedge clk) begin
        if (!rst_n || line_in)                          low_cnt <= '0;
        else if (us_tick && low_cnt < 16'(RST_US))      low_cnt <= low_cnt + 1'b1;
    end

    // Remember that at least one valid reset pulse has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed <= 1'b0;
        else if (low_cnt == 16'(RST_US))    armed <= 1'b1;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !dropped && !pull_low));

    a_r2_long_low_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt == 16'(RST_US)) |=> (!busy && !dropped));

    a_r3_presence_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_low) && !busy) |-> armed);

    a_r7_dropped_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> (!pull_low && !busy));

    a_r7_drop_only_in_search: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dropped) |-> $past(busy));

endmodule

bind owire_rom_slave owrs_checker #(.RST_US(RST_US)) u_chk (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
    .pull_low(pull_low), .busy(busy), .dropped(dropped)
);

// File: tb/sim_owire_rom_slave.sv
// Bench: two responders with different identities share one wired-AND line.
module sim_owire_rom_slave;

    localparam logic [63:0] ROM_A = 64'h5E00_A1B2_C3D4_E528;
    localparam logic [63:0] ROM_B = 64'h5E00_A1B2_C3D4_F528;
    localparam logic [63:0] ROM_AND = ROM_A & ROM_B;

    // Vector: {kind[1:0], command[7:0]}; kind 0 silent, 1 read, 2 search A, 3 search B.
    localparam logic [9:0] VEC [0:5] = '{
        {2'd1, 8'h33}, {2'd0, 8'h55}, {2'd2, 8'hF0},
        {2'd0, 8'hCC}, {2'd0, 8'hA5}, {2'd3, 8'hF0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic m_low = 1'b0;
    logic pl0, pl1, busy0, busy1, drop0, drop1;
    logic line;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    assign line = !(m_low || pl0 || pl1);

    always #4 clk = ~clk;

    owire_rom_slave #(.ROM_CODE(ROM_A)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
        .pull_low(pl0), .busy(busy0), .dropped(drop0)
    );

    owire_rom_slave #(.ROM_CODE(ROM_B)) u1 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
        .pull_low(pl1), .busy(busy1), .dropped(drop1)
    );

    // One microsecond is two clock cycles in this bench.
    initial forever begin
        @(negedge clk);
        us_tick = ~us_tick;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic write_bit(input bit b);
        m_low = 1'b1;
        wait_us(b ? 6 : 60);
        m_low = 1'b0;
        wait_us(b ? 64 : 10);
    endtask

    task automatic read_bit(output bit b);
        m_low = 1'b1;
        wait_us(2);
        m_low = 1'b0;
        wait_us(13);
        b = line;
        wait_us(55);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic do_reset(input string tag);
        int first;
        int len;
        first = -1;
        len = 0;
        m_low = 1'b1;
        wait_us(500);
        m_low = 1'b0;
        for (int t = 0; t < 300; t++) begin
            wait_us(1);
            if (!line) begin
                if (first < 0) first = t;
                len++;
            end
        end
        check(first >= 15 && first <= 60, {"R3 presence start ", tag}, 64'(first), 64'd30);
        check(len >= 60 && len <= 240, {"R3 presence length ", tag}, 64'(len), 64'd120);
        check(busy0 && busy1 && !drop0 && !drop1, {"R4 R10 busy set, dropped clear ", tag},
              {60'd0, busy0, busy1, drop0, drop1}, 64'hC);
    endtask

    task automatic search(input bit pick_b);
        bit a_on, b_on, r1, r2, w, e1, e2;
        a_on = 1'b1;
        b_on = 1'b1;
        for (int i = 0; i < 64; i++) begin
            e1 = (a_on ? ROM_A[i] : 1'b1) & (b_on ? ROM_B[i] : 1'b1);
            e2 = (a_on ? !ROM_A[i] : 1'b1) & (b_on ? !ROM_B[i] : 1'b1);
            read_bit(r1);
            read_bit(r2);
            check(r1 == e1, "R6 R9 search true slot", 64'(r1), 64'(e1));
            check(r2 == e2, "R6 R9 search inverse slot", 64'(r2), 64'(e2));
            w = pick_b ? ROM_B[i] : ROM_A[i];
            write_bit(w);
            if (ROM_A[i] != w) a_on = 1'b0;
            if (ROM_B[i] != w) b_on = 1'b0;
            check(drop0 == !a_on && drop1 == !b_on, "R7 drop-out flags",
                  {62'd0, drop0, drop1}, {62'd0, !a_on, !b_on});
        end
        check(!busy0 && !busy1, "R7 busy low after search", {62'd0, busy0, busy1}, 64'd0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        bit b;
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line && !busy0 && !busy1 && !drop0 && !drop1, "R1 state after rst_n",
              {59'd0, line, busy0, busy1, drop0, drop1}, 64'h10);

        // Short low pulse and a command before any valid reset: no reply (R1, R3).
        m_low = 1'b1;
        wait_us(100);
        m_low = 1'b0;
        lows = 0;
        for (int t = 0; t < 300; t++) begin
            wait_us(1);
            if (!line) lows++;
        end
        check(lows == 0, "R3 no presence after short low", 64'(lows), 64'd0);
        write_byte(8'h33);
        got = '1;
        for (int i = 0; i < 8; i++) begin read_bit(b); got[i] = b; end
        check(got[7:0] == 8'hFF && !busy0, "R1 silent before first reset", got, 64'hFF);

        // Table of command vectors.
        for (int v = 0; v < 6; v++) begin
            do_reset("table");
            write_byte(VEC[v][7:0]);
            case (VEC[v][9:8])
                2'd1: begin
                    for (int i = 0; i < 64; i++) begin read_bit(b); got[i] = b; end
                    check(got == ROM_AND, "R4 R5 R9 identity read wired-AND", got, ROM_AND);
                    check(!busy0 && !busy1, "R5 busy low after 64 bits", {62'd0, busy0, busy1}, 64'd0);
                end
                2'd2: search(1'b0);
                2'd3: search(1'b1);
                default: begin
                    got = '0;
                    for (int i = 0; i < 16; i++) begin read_bit(b); got[i] = b; end
                    check(got[15:0] == 16'hFFFF, "R8 unsupported command silent", got, 64'hFFFF);
                    check(!busy0 && !busy1 && !drop0, "R8 busy low after unsupported",
                          {61'd0, busy0, busy1, drop0}, 64'd0);
                end
            endcase
        end
        check(drop0 && !drop1, "R7 loser stays dropped until reset", {62'd0, drop0, drop1}, 64'h2);

        // Reset clears drop-out; reset in the middle of a read aborts it (R2, R10).
        do_reset("R10 clear");
        write_byte(8'h33);
        for (int i = 0; i < 5; i++) begin read_bit(b); got[i] = b; end
        check(got[4:0] == ROM_AND[4:0], "R10 read after drop-out clear", 64'(got[4:0]), 64'(ROM_AND[4:0]));
        do_reset("R2 abort");
        write_byte(8'h33);
        for (int i = 0; i < 8; i++) begin read_bit(b); got[i] = b; end
        check(got[7:0] == ROM_AND[7:0], "R2 fresh read starts at bit 0", 64'(got[7:0]), 64'(ROM_AND[7:0]));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule